// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control unit that takes a small instruction-cycle processor core into and out of interrupt handlers. Each clock edge is one instruction cycle. Peripheral events are caught in per-source pending flags. Once the instruction in progress has finished, the block runs a fixed entry sequence. It pushes the return address and the low status byte onto an external save stack. It drives the vector-table slot address for the chosen source onto the PC. It then loads the handler address read from that slot. While all this happens it injects no-operation cycles, so entry timing is the same whether the interrupted instruction took one cycle or two.

A decoded return instruction starts a matching exit sequence. The stack is popped, the PC and status are reloaded, and one no-operation fetch cycle follows before normal execution resumes. From the save cycle until the status has been restored, new requests are not accepted. They stay latched in their flags and are served after the return. When several flags are pending, the lowest source index is taken. This fixed pick stands in for a real priority arbiter.

The state machine has six states. RUN is normal execution. SAVE is the push cycle and is a no-op. VECT drives the slot address to the PC and reads the table; it is also a no-op. JUMP loads the handler address and is a no-op. RLOAD loads the popped PC and status. RNOP is the restart fetch and is a no-op. The transitions are:
- RUN→SAVE (accept): a flag is pending, the block is unmasked, the current cycle ends an instruction, and no return is decoded.
- RUN→RLOAD (return): a return is decoded.
- SAVE→VECT, VECT→JUMP, JUMP→RUN, RLOAD→RNOP and RNOP→RUN: these happen unconditionally.

Top module: `irq_entry_seq`

## Requirements
- R1: A one on `irq_evt[i]` sets `irq_flags[i]` at the next clock edge. A flag stays set until its source is accepted, including events that arrive during an entry or return sequence. An event on the acceptance edge re-sets the flag.
- R2: Entry is accepted only in a RUN cycle with `instr_last`=1. If the event lands in the first cycle of a two-cycle instruction, the save cycle waits until the cycle after `instr_last` is seen.
- R3: The save cycle is the cycle after acceptance. In it, `stk_push`=1, `stk_push_pc`=`pc_cur`, `stk_push_st`=`status_lo` and `nop_inject`=1. The accepted source's flag reads zero from the save cycle on.
- R4: The cycle after the save cycle is the vector cycle. In it, `vec_rd`=1, `vec_addr`=VEC_BASE+idx*VEC_STRIDE, `pc_load`=1 with `pc_load_val`=`vec_addr`, and `nop_inject`=1.
- R5: The cycle after the vector cycle is the jump cycle. In it, `pc_load`=1 with `pc_load_val` equal to the `vec_data` sampled in the vector cycle, and `nop_inject`=1. The next cycle is RUN.
- R6: `irq_masked` is 1 from the save cycle through the restore cycle and 0 in the cycle after it. No entry is accepted while it is 1.
- R7: A RUN cycle with `ret_decode`=1 asserts `stk_pop` in that same cycle. The next cycle asserts `pc_load` and `st_load` with the popped PC and status. The cycle after that has `nop_inject`=1 and no loads, and then RUN resumes.
- R8: When several flags are pending at acceptance, the lowest index is taken.
- R9: During reset, all flags, `irq_masked` and every strobe output are 0.
- R10: If `ret_decode` and an acceptable entry coincide in a RUN cycle, the return is taken and the entry waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_evt | input | NSRC | Per-source peripheral event pulses |
| instr_last | input | 1 | Current cycle completes an instruction |
| ret_decode | input | 1 | Return-from-interrupt decoded this cycle |
| pc_cur | input | PCW | Address of the next instruction to run |
| status_lo | input | SW | Low status byte |
| vec_rd | output | 1 | Vector-table read strobe |
| vec_addr | output | PCW | Vector-table slot address |
| vec_data | input | PCW | Handler address read from the slot |
| stk_push | output | 1 | Save-stack push strobe |
| stk_push_pc | output | PCW | PC value pushed |
| stk_push_st | output | SW | Status value pushed |
| stk_pop | output | 1 | Save-stack pop strobe |
| stk_pop_pc | input | PCW | PC at top of the save stack |
| stk_pop_st | input | SW | Status at top of the save stack |
| pc_load | output | 1 | Load PC this cycle |
| pc_load_val | output | PCW | Value loaded into the PC |
| st_load | output | 1 | Load low status this cycle |
| st_load_val | output | SW | Value loaded into the status |
| nop_inject | output | 1 | Execute this cycle as a no-op |
| irq_flags | output | NSRC | Pending interrupt flags |
| irq_masked | output | 1 | Interrupt acceptance masked |

## Verification
The assertions check the fixed ordering on every cycle:
- a push is always followed by a vector read, and the read by a handler load;
- a pop is followed by the restore loads carrying the popped values;
- a push only follows an instruction-completing cycle;
- the mask is high during the push and drops right after the restore;
- flags set after events;
- the strobes never overlap.

Only the bench scenarios can show the exact cycle on which the PC changes relative to the event, the lowest-index pick, the extra wait for a two-cycle instruction, and the return winning over a pending request. The bench compares every output against its behavioural model in every cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        SQ_RUN   = 3'd0,
        SQ_SAVE  = 3'd1,
        SQ_VECT  = 3'd2,
        SQ_JUMP  = 3'd3,
        SQ_RLOAD = 3'd4,
        SQ_RNOP  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned NSRC = 4,
    localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            clr_en,
    input  logic [IDXW-1:0] clr_idx,
    output logic [NSRC-1:0] flags,
    output logic            any_pend,
    output logic [IDXW-1:0] pick_idx
);

    logic [NSRC-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
    end

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[gi] <= 1'b0;
            else
                flags[gi] <= (flags[gi] & ~clr_vec[gi]) | evt[gi];
        end
    end

    always_comb begin
        pick_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (flags[i]) pick_idx = IDXW'(i);
        end
    end

    assign any_pend = |flags;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R1

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int unsigned NSRC       = 4,
    parameter int unsigned PCW        = 16,
    parameter int unsigned VEC_BASE   = 8,
    parameter int unsigned VEC_STRIDE = 4,
    localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [IDXW-1:0] idx,
    output logic [PCW-1:0]  slot_addr
);

    logic [PCW-1:0] slot_tab [NSRC];

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_slot
        assign slot_tab[gi] = PCW'(VEC_BASE + gi * VEC_STRIDE);
    end

    assign slot_addr = slot_tab[idx];

endmodule

// File: rtl/irq_ctx_hold.sv
module irq_ctx_hold #(
    parameter int unsigned PCW = 16,
    parameter int unsigned SW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_handler,
    input  logic [PCW-1:0] handler_in,
    input  logic           cap_ret,
    input  logic [PCW-1:0] ret_pc_in,
    input  logic [SW-1:0]  ret_st_in,
    output logic [PCW-1:0] handler_q,
    output logic [PCW-1:0] ret_pc_q,
    output logic [SW-1:0]  ret_st_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            handler_q <= '0;
        end else if (cap_handler) begin
            handler_q <= handler_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_pc_q <= '0;
            ret_st_q <= '0;
        end else if (cap_ret) begin
            ret_pc_q <= ret_pc_in;
            ret_st_q <= ret_st_in;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned NSRC       = 4,
    parameter int unsigned PCW        = 16,
    parameter int unsigned SW         = 8,
    parameter int unsigned VEC_BASE   = 8,
    parameter int unsigned VEC_STRIDE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_evt,
    input  logic            instr_last,
    input  logic            ret_decode,
    input  logic [PCW-1:0]  pc_cur,
    input  logic [SW-1:0]   status_lo,
    output logic            vec_rd,
    output logic [PCW-1:0]  vec_addr,
    input  logic [PCW-1:0]  vec_data,
    output logic            stk_push,
    output logic [PCW-1:0]  stk_push_pc,
    output logic [SW-1:0]   stk_push_st,
    output logic            stk_pop,
    input  logic [PCW-1:0]  stk_pop_pc,
    input  logic [SW-1:0]   stk_pop_st,
    output logic            pc_load,
    output logic [PCW-1:0]  pc_load_val,
    output logic            st_load,
    output logic [SW-1:0]   st_load_val,
    output logic            nop_inject,
    output logic [NSRC-1:0] irq_flags,
    output logic            irq_masked
);

    localparam int unsigned IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

    seq_state_e      state_q, state_d;
    logic            mask_q;
    logic [IDXW-1:0] sel_q;
    logic            any_pend;
    logic [IDXW-1:0] pick_idx;
    logic            accept, ret_go;
    logic [PCW-1:0]  slot_addr;
    logic [PCW-1:0]  handler_q, ret_pc_q;
    logic [SW-1:0]   ret_st_q;

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (irq_evt),
        .clr_en   (accept),
        .clr_idx  (pick_idx),
        .flags    (irq_flags),
        .any_pend (any_pend),
        .pick_idx (pick_idx)
    );

    irq_vec_gen #(
        .NSRC(NSRC), .PCW(PCW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_vec (
        .idx       (sel_q),
        .slot_addr (slot_addr)
    );

    irq_ctx_hold #(.PCW(PCW), .SW(SW)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_handler (vec_rd),
        .handler_in  (vec_data),
        .cap_ret     (ret_go),
        .ret_pc_in   (stk_pop_pc),
        .ret_st_in   (stk_pop_st),
        .handler_q   (handler_q),
        .ret_pc_q    (ret_pc_q),
        .ret_st_q    (ret_st_q)
    );

    assign ret_go = (state_q == SQ_RUN) && ret_decode;
    assign accept = (state_q == SQ_RUN) && !ret_decode && any_pend
                    && !mask_q && instr_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_RUN: begin
                if (ret_go)      state_d = SQ_RLOAD;
                else if (accept) state_d = SQ_SAVE;
            end
            SQ_SAVE:  state_d = SQ_VECT;
            SQ_VECT:  state_d = SQ_JUMP;
            SQ_JUMP:  state_d = SQ_RUN;
            SQ_RLOAD: state_d = SQ_RNOP;
            SQ_RNOP:  state_d = SQ_RUN;
            default:  state_d = SQ_RUN;
        endcase
    end

    // mask and selected source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (accept) begin
                mask_q <= 1'b1;
                sel_q  <= pick_idx;
            end else if (state_q == SQ_RLOAD) begin
                mask_q <= 1'b0;
            end
        end
    end

    assign irq_masked = mask_q;

    // outputs
    always_comb begin
        vec_rd      = 1'b0;
        vec_addr    = '0;
        stk_push    = 1'b0;
        stk_push_pc = '0;
        stk_push_st = '0;
        pc_load     = 1'b0;
        pc_load_val = '0;
        st_load     = 1'b0;
        st_load_val = '0;
        nop_inject  = 1'b0;
        unique case (state_q)
            SQ_RUN: ;
            SQ_SAVE: begin
                stk_push    = 1'b1;
                stk_push_pc = pc_cur;
                stk_push_st = status_lo;
                nop_inject  = 1'b1;
            end
            SQ_VECT: begin
                vec_rd      = 1'b1;
                vec_addr    = slot_addr;
                pc_load     = 1'b1;
                pc_load_val = slot_addr;
                nop_inject  = 1'b1;
            end
            SQ_JUMP: begin
                pc_load     = 1'b1;
                pc_load_val = handler_q;
                nop_inject  = 1'b1;
            end
            SQ_RLOAD: begin
                pc_load     = 1'b1;
                pc_load_val = ret_pc_q;
                st_load     = 1'b1;
                st_load_val = ret_st_q;
            end
            SQ_RNOP: nop_inject = 1'b1;
            default: ;
        endcase
    end

    assign stk_pop = ret_go;

    AST_SAVE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |-> $past(instr_last)); // R2
    AST_SAVE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |-> irq_masked); // R6
    AST_VECT_FOLLOWS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> (vec_rd && nop_inject && pc_load)); // R4
    AST_JUMP_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd |=> (pc_load && nop_inject && pc_load_val == $past(vec_data))); // R5
    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |=> (pc_load && st_load && pc_load_val == $past(stk_pop_pc)
                     && st_load_val == $past(stk_pop_st))); // R7
    AST_UNMASK_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_load |=> (!irq_masked && nop_inject && !pc_load)); // R6
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_push, vec_rd, stk_pop, st_load})); // R3

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

    localparam int NS = 4, PCW = 16, SW = 8, VB = 8, VS = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic [NS-1:0] irq_evt = '0;
    logic instr_last = 1'b1, ret_decode = 1'b0;
    logic [PCW-1:0] pc_cur = 16'h0100;
    logic [SW-1:0]  status_lo = '0;
    logic [PCW-1:0] vec_data = '0, stk_pop_pc = '0;
    logic [SW-1:0]  stk_pop_st = '0;
    logic vec_rd, stk_push, stk_pop, pc_load, st_load, nop_inject, irq_masked;
    logic [PCW-1:0] vec_addr, stk_push_pc, pc_load_val;
    logic [SW-1:0]  stk_push_st, st_load_val;
    logic [NS-1:0]  irq_flags;

    irq_entry_seq #(.NSRC(NS), .PCW(PCW), .SW(SW), .VEC_BASE(VB), .VEC_STRIDE(VS)) uut (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .instr_last(instr_last),
        .ret_decode(ret_decode), .pc_cur(pc_cur), .status_lo(status_lo),
        .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_data(vec_data),
        .stk_push(stk_push), .stk_push_pc(stk_push_pc), .stk_push_st(stk_push_st),
        .stk_pop(stk_pop), .stk_pop_pc(stk_pop_pc), .stk_pop_st(stk_pop_st),
        .pc_load(pc_load), .pc_load_val(pc_load_val), .st_load(st_load),
        .st_load_val(st_load_val), .nop_inject(nop_inject),
        .irq_flags(irq_flags), .irq_masked(irq_masked)
    );

    int checks = 0, fails = 0, cyc = 0;
    string scen = "R9 reset";
    bit run = 1'b0;

    // behavioural reference: phase 0 run, 1..3 entry, 11..12 return
    int ph = 0, sel = 0;
    logic [NS-1:0] mfl = '0;
    bit mmsk = 1'b0;
    logic [PCW-1:0] mhand = '0, mrpc = '0;
    logic [SW-1:0]  mrst = '0;
    logic [PCW+SW-1:0] stkq [$];

    function automatic int lowest(logic [NS-1:0] f);
        for (int i = 0; i < NS; i++) if (f[i]) return i;
        return 0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s [%s] actual=%0h expected=%0h", tag, what, scen, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            #2;
            chk("R3", 32'(stk_push), 32'(ph == 1), "stk_push");
            if (ph == 1) begin
                chk("R3", 32'(stk_push_pc), 32'(pc_cur), "push pc");
                chk("R3", 32'(stk_push_st), 32'(status_lo), "push status");
            end
            chk("R4", 32'(vec_rd), 32'(ph == 2), "vec_rd");
            if (ph == 2) begin
                chk("R4", 32'(vec_addr), 32'(VB + sel * VS), "vec_addr");
                chk("R4", 32'(pc_load_val), 32'(VB + sel * VS), "pc to slot");
            end
            chk("R5", 32'(pc_load), 32'(ph == 2 || ph == 3 || ph == 11), "pc_load");
            if (ph == 3)  chk("R5", 32'(pc_load_val), 32'(mhand), "pc to handler");
            if (ph == 11) begin
                chk("R7", 32'(pc_load_val), 32'(mrpc), "restored pc");
                chk("R7", 32'(st_load_val), 32'(mrst), "restored status");
            end
            chk("R7", 32'(st_load), 32'(ph == 11), "st_load");
            chk("R7", 32'(stk_pop), 32'(rst_n && ph == 0 && ret_decode), "stk_pop");
            chk("R5", 32'(nop_inject), 32'(ph == 1 || ph == 2 || ph == 3 || ph == 12), "nop_inject");
            chk("R1", 32'(irq_flags), 32'(mfl), "irq_flags");
            chk("R6", 32'(irq_masked), 32'(mmsk), "irq_masked");
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            bit take;
            bit retgo;
            int lo;
            logic [NS-1:0] clr;
            lo    = lowest(mfl);
            retgo = (ph == 0) && ret_decode;
            take  = (ph == 0) && !ret_decode && (mfl != 0) && !mmsk && instr_last;
            clr   = take ? (NS'(1) << lo) : '0;
            if (ph == 1) stkq.push_back({pc_cur, status_lo});
            case (ph)
                0: begin
                    if (retgo) begin
                        mrpc = stk_pop_pc; mrst = stk_pop_st; ph = 11;
                        if (stkq.size() > 0) void'(stkq.pop_back());
                    end else if (take) begin
                        sel = lo; mmsk = 1'b1; ph = 1;
                    end
                end
                1: ph = 2;
                2: begin mhand = vec_data; ph = 3; end
                3: ph = 0;
                11: begin mmsk = 1'b0; ph = 12; end
                default: ph = 0;
            endcase
            mfl = (mfl & ~clr) | irq_evt;
        end
    end

    task automatic step(logic [NS-1:0] evt, logic last, logic ret);
        @(negedge clk);
        irq_evt = evt; instr_last = last; ret_decode = ret;
        pc_cur = pc_cur + 16'd2;
        status_lo = pc_cur[7:0] ^ 8'h5a;
        vec_data = 16'h4000 + 16'($urandom % 4096);
        if (stkq.size() > 0) {stk_pop_pc, stk_pop_st} = stkq[$];
        else {stk_pop_pc, stk_pop_st} = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog expired [%s]", scen);
            finish_run();
        end
    end

    initial begin
        run = 1'b1;
        repeat (3) step('0, 1'b1, 1'b0);   // R9 reset values
        @(negedge clk) rst_n = 1'b1;

        scen = "R3 single source entry";
        step(4'b0100, 1'b1, 1'b0);
        repeat (7) step('0, 1'b1, 1'b0);
        scen = "R7 return sequence";
        step('0, 1'b1, 1'b1);
        repeat (5) step('0, 1'b1, 1'b0);

        scen = "R2 two-cycle instruction";
        step(4'b0001, 1'b1, 1'b0);
        step('0, 1'b0, 1'b0);
        repeat (8) step('0, 1'b1, 1'b0);
        step('0, 1'b1, 1'b1);
        repeat (4) step('0, 1'b1, 1'b0);

        scen = "R8 lowest index first";
        step(4'b1010, 1'b1, 1'b0);
        repeat (3) step('0, 1'b1, 1'b0);
        scen = "R6 masked while in handler";
        step(4'b0001, 1'b1, 1'b0);
        repeat (3) begin
            repeat (8) step('0, 1'b1, 1'b0);
            step('0, 1'b1, 1'b1);
        end
        repeat (6) step('0, 1'b1, 1'b0);

        scen = "R10 return wins over pending";
        step(4'b0100, 1'b0, 1'b0);
        step('0, 1'b1, 1'b1);
        repeat (8) step('0, 1'b1, 1'b0);
        step('0, 1'b1, 1'b1);
        repeat (4) step('0, 1'b1, 1'b0);

        scen = "R1 mixed traffic";
        for (int i = 0; i < 600; i++) begin
            logic [NS-1:0] e;
            e = ($urandom % 9 == 0) ? NS'($urandom) : '0;
            step(e, 1'($urandom % 3 != 0), 1'(mmsk && ph == 0 && ($urandom % 5 == 0)));
        end
        repeat (4) step('0, 1'b1, 1'b0);
        @(negedge clk);
        #5;
        finish_run();
    end

endmodule